// File: doc/BRIEF.md
# Sixteen-Bit Timer with Compare-Triggered Clear

This block is a 16-bit up-counter that sits behind a byte-wide register port. Software controls it through a control byte, reads and writes the count one byte at a time, and handles a sticky overflow flag with an enable that gates the interrupt line. The count source is either the system clock or an external tick that is already synchronized. Either source passes through a prescaler that divides by 1, 2, 4 or 8.

A pulse from a compare unit can clear the count. The compare value then sets the timer period. This clear never raises the overflow flag. If software writes the count in the same cycle as the pulse, the write wins. A two-state run machine gates counting. In ST_HALT the count and the prescaler hold. The GO transition moves ST_HALT to ST_COUNT when the run bit reads 1. The STOP transition moves ST_COUNT back to ST_HALT when the run bit reads 0. Each transition takes effect one clock after the control write.

In 16-bit access mode, reading the low byte captures the high byte so that a 16-bit read is coherent. A high-byte write waits in a buffer and is loaded together with the next low-byte write.

Top module: `cmp_timer16`

## Requirements
- R1: Register addresses are 0 = control, 1 = count low byte, 2 = count high byte, 3 = interrupt register (bit 0 = overflow flag, bit 1 = interrupt enable). After reset all four read 0x00.
- R2: Each counting step adds 1 to the count. A step taken at 0xFFFF gives 0x0000 and sets the overflow flag.
- R3: The overflow flag stays set until software writes address 3 with bit 0 = 0. Writing bit 0 = 1 leaves the flag unchanged. Bit 1 of the same write sets the enable. `irq_o` is 1 exactly when both the flag and the enable are 1.
- R4: Control bits {6,3} select the trigger source: 00 = none, 01 = `trig_a`, 10 or 11 = `trig_b`. A pulse on the selected input sets the count to 0x0000, and it has priority over a counting step in the same cycle.
- R5: A trigger-caused clear never sets the overflow flag, even when the count is 0xFFFF.
- R6: A count write in the same cycle as a trigger loads the written value, and the trigger has no effect.
- R7: When control bit 1 = 1 (external source) and bit 2 = 1 (synchronization disabled), trigger pulses are ignored.
- R8: Control bits 5:4 = 00, 01, 10, 11 divide the count source by 1, 2, 4, 8. Every count write and every honoured trigger clears the prescaler.
- R9: Control bit 1 selects the source: 0 = every clock, 1 = `ext_tick`. Control bit 0 is the run bit. While the machine is in ST_HALT the count and the prescaler hold, but register writes still act.
- R10: With control bit 7 = 1, a low-byte read captures the high byte, and later high-byte reads return the captured value. A high-byte write is buffered and is loaded with the next low-byte write as {buffer, low}.
- R11: With control bit 7 = 0, the high and low bytes are read and written directly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (drives read side effects) |
| addr | input | 2 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` |
| ext_tick | input | 1 | Synchronized external count enable |
| trig_a | input | 1 | Special-event pulse from compare unit A |
| trig_b | input | 1 | Special-event pulse from compare unit B |
| irq_o | output | 1 | Interrupt request |

## Verification
Two events can land in the same clock: a trigger clear together with a count write, and a trigger clear together with the counting step that would wrap 0xFFFF. The bench drives both in one cycle. A low-byte write is paired with `trig_a` in both 8-bit and 16-bit modes, and the bench expects the written bytes to survive (0x1255 and 0xABCD). An external tick is paired with `trig_a` at 0xFFFF, and the bench expects count 0x0000 with the overflow flag still clear.

// File: rtl/tmr16_pkg.sv
package tmr16_pkg;
    localparam int BYTE_W = 8;
    localparam int ADDR_W = 2;

    localparam logic [ADDR_W-1:0] A_CTL = 2'd0;
    localparam logic [ADDR_W-1:0] A_LO  = 2'd1;
    localparam logic [ADDR_W-1:0] A_HI  = 2'd2;
    localparam logic [ADDR_W-1:0] A_IRQ = 2'd3;

    localparam int B_WIDE   = 7;
    localparam int B_TSEL_H = 6;
    localparam int B_PS_H   = 5;
    localparam int B_PS_L   = 4;
    localparam int B_TSEL_L = 3;
    localparam int B_NOSYNC = 2;
    localparam int B_EXT    = 1;
    localparam int B_RUN    = 0;

    typedef enum logic {
        ST_HALT  = 1'b0,
        ST_COUNT = 1'b1
    } run_state_t;
endpackage

// File: rtl/tmr16_prescaler.sv
module tmr16_prescaler #(
    parameter int SEL_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             en,
    input  logic [SEL_W-1:0] sel,
    output logic             step
);
    localparam int MAX_SHIFT = (1 << SEL_W) - 1;
    localparam int PC_W = (MAX_SHIFT > 0) ? MAX_SHIFT : 1;

    logic [PC_W-1:0] pc_q;
    logic [PC_W-1:0] mask;

    always_comb begin
        mask = '0;
        for (int i = 0; i < PC_W; i++) begin
            if (i < int'(sel)) mask[i] = 1'b1;
        end
    end

    assign step = en && !clr && (pc_q == mask);

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            pc_q <= '0;
        end else if (en) begin
            if (pc_q == mask) pc_q <= '0;
            else              pc_q <= pc_q + 1'b1;
        end
    end
endmodule

// File: rtl/tmr16_core.sv
module tmr16_core #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    input  logic             trig,
    input  logic             ld,
    input  logic [CNT_W-1:0] ld_val,
    output logic [CNT_W-1:0] cnt,
    output logic             ovf
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] cnt_q;

    assign cnt = cnt_q;
    assign ovf = step && !ld && !trig && (cnt_q == CNT_MAX);

    always_ff @(posedge clk) begin
        if (!rst_n)     cnt_q <= '0;
        else if (ld)    cnt_q <= ld_val;
        else if (trig)  cnt_q <= '0;
        else if (step)  cnt_q <= cnt_q + 1'b1;
    end

    // R6
    wr_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ld |=> cnt_q == $past(ld_val));

    // R4
    trig_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trig && !ld) |=> cnt_q == '0);

    // R2
    wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !ld && !trig && cnt_q == CNT_MAX) |=> cnt_q == '0);
endmodule

// File: rtl/cmp_timer16.sv
module cmp_timer16
    import tmr16_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] rdata,
    input  logic              ext_tick,
    input  logic              trig_a,
    input  logic              trig_b,
    output logic              irq_o
);
    localparam int CNT_W = 2 * BYTE_W;

    logic [BYTE_W-1:0] ctl_q;
    logic              flag_q, ien_q;
    logic [BYTE_W-1:0] hwr_q, hrd_q;
    run_state_t        st_q, st_d;
    logic              running;

    logic [CNT_W-1:0]  cnt;
    logic [CNT_W-1:0]  cnt_wval;
    logic              cnt_wr, ovf, step, trig_pick, trig_eff, tick_src;

    wire wr_ctl = wr_en && (addr == A_CTL);
    wire wr_lo  = wr_en && (addr == A_LO);
    wire wr_hi  = wr_en && (addr == A_HI);
    wire wr_irq = wr_en && (addr == A_IRQ);
    wire rd_lo  = rd_en && (addr == A_LO);

    wire       wide   = ctl_q[B_WIDE];
    wire [1:0] tsel   = {ctl_q[B_TSEL_H], ctl_q[B_TSEL_L]};
    wire [1:0] psel   = ctl_q[B_PS_H:B_PS_L];
    wire       nosync = ctl_q[B_NOSYNC];
    wire       ext    = ctl_q[B_EXT];
    wire       run    = ctl_q[B_RUN];

    // Run machine: state register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_HALT;
        else        st_q <= st_d;
    end

    // Run machine: transitions GO and STOP
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_HALT:  if (run)  st_d = ST_COUNT;
            ST_COUNT: if (!run) st_d = ST_HALT;
        endcase
    end

    // Run machine: outputs
    always_comb begin
        running = 1'b0;
        unique case (st_q)
            ST_HALT:  running = 1'b0;
            ST_COUNT: running = 1'b1;
        endcase
    end

    always_comb begin
        unique case (tsel)
            2'b00:   trig_pick = 1'b0;
            2'b01:   trig_pick = trig_a;
            default: trig_pick = trig_b;
        endcase
    end

    assign trig_eff = trig_pick && !(ext && nosync);
    assign tick_src = ext ? ext_tick : 1'b1;
    assign cnt_wr   = wr_lo || (wr_hi && !wide);

    always_comb begin
        if (wr_lo) cnt_wval = wide ? {hwr_q, wdata} : {cnt[CNT_W-1:BYTE_W], wdata};
        else       cnt_wval = {wdata, cnt[BYTE_W-1:0]};
    end

    tmr16_prescaler #(.SEL_W(2)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (cnt_wr || trig_eff),
        .en    (running && tick_src),
        .sel   (psel),
        .step  (step)
    );

    tmr16_core #(.CNT_W(CNT_W)) u_core (
        .clk    (clk),
        .rst_n  (rst_n),
        .step   (step),
        .trig   (trig_eff),
        .ld     (cnt_wr),
        .ld_val (cnt_wval),
        .cnt    (cnt),
        .ovf    (ovf)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q  <= '0;
            flag_q <= 1'b0;
            ien_q  <= 1'b0;
            hwr_q  <= '0;
            hrd_q  <= '0;
        end else begin
            if (wr_ctl) ctl_q <= wdata;
            if (wr_hi && wide) hwr_q <= wdata;
            if (rd_lo && wide) hrd_q <= cnt[CNT_W-1:BYTE_W];
            if (wr_irq) ien_q <= wdata[1];
            if (ovf)         flag_q <= 1'b1;
            else if (wr_irq) flag_q <= flag_q & wdata[0];
        end
    end

    always_comb begin
        unique case (addr)
            A_CTL:   rdata = ctl_q;
            A_LO:    rdata = cnt[BYTE_W-1:0];
            A_HI:    rdata = wide ? hrd_q : cnt[CNT_W-1:BYTE_W];
            default: rdata = {{(BYTE_W-2){1'b0}}, ien_q, flag_q};
        endcase
    end

    assign irq_o = flag_q && ien_q;

    // R3
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && !(wr_irq && !wdata[0])) |=> flag_q);

    // R5
    trig_noflag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag_q && trig_eff && !(wr_irq && wdata[0] == 1'b0 && 1'b0)) |=> !flag_q);

    // R9
    halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_HALT && !cnt_wr && !trig_eff) |=> $stable(cnt));
endmodule

// File: tb/tb_cmp_timer16.sv
module tb_cmp_timer16;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0, rd_en = 1'b0;
    logic [1:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       ext_tick = 1'b0, trig_a = 1'b0, trig_b = 1'b0;
    logic       irq_o;

    int n_chk = 0;
    int n_fail = 0;

    typedef struct {
        logic [7:0] exp;
        logic [1:0] a;
        string      tag;
    } item_t;
    item_t sb_q[$];

    always #5 clk = ~clk;

    cmp_timer16 dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata),
        .ext_tick(ext_tick), .trig_a(trig_a), .trig_b(trig_b), .irq_o(irq_o)
    );

    // Monitor: compares each read against the scoreboard
    always @(negedge clk) begin
        if (rst_n && rd_en) begin
            if (sb_q.size() == 0) begin
                n_chk++; n_fail++;
                $display("FAIL scoreboard: read with no expectation, got %h", rdata);
            end else begin
                item_t it;
                it = sb_q.pop_front();
                n_chk++;
                if (rdata !== it.exp) begin
                    n_fail++;
                    $display("FAIL %s: addr %0d actual %h expected %h", it.tag, it.a, rdata, it.exp);
                end
            end
        end
    end

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, input logic [7:0] e, input string tag);
        item_t it;
        it.exp = e; it.a = a; it.tag = tag;
        sb_q.push_back(it);
        rd_en = 1'b1; addr = a;
        @(posedge clk); #1;
        rd_en = 1'b0;
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            ext_tick = 1'b1;
            @(posedge clk); #1;
            ext_tick = 1'b0;
        end
    endtask

    task automatic pulse(input logic a, input logic b, input logic t);
        trig_a = a; trig_b = b; ext_tick = t;
        @(posedge clk); #1;
        trig_a = 1'b0; trig_b = 1'b0; ext_tick = 1'b0;
    endtask

    task automatic wr_trig(input logic [1:0] a, input logic [7:0] d);
        wr_en = 1'b1; addr = a; wdata = d; trig_a = 1'b1;
        @(posedge clk); #1;
        wr_en = 1'b0; trig_a = 1'b0;
    endtask

    task automatic setctl(input logic [7:0] c);
        wr(2'd0, c);
        idle(2);
    endtask

    task automatic set8(input logic [15:0] v);
        wr(2'd2, v[15:8]);
        wr(2'd1, v[7:0]);
    endtask

    task automatic chk_irq(input logic e, input string tag);
        n_chk++;
        if (irq_o !== e) begin
            n_fail++;
            $display("FAIL %s: irq_o actual %b expected %b", tag, irq_o, e);
        end
    endtask

    initial begin
        #2_000_000;
        n_fail++;
        $display("FAIL watchdog: run did not complete, actual hung expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        idle(1);

        // R1 reset state
        rd(2'd0, 8'h00, "R1 ctl");
        rd(2'd1, 8'h00, "R1 lo");
        rd(2'd2, 8'h00, "R1 hi");
        rd(2'd3, 8'h00, "R1 irq");
        chk_irq(1'b0, "R1 irq_o");

        // R11 direct byte access
        set8(16'h1234);
        rd(2'd2, 8'h12, "R11 hi");
        rd(2'd1, 8'h34, "R11 lo");

        // R2 / R3 overflow and sticky flag (ext, run, div1, select A)
        setctl(8'h0B);
        set8(16'hFFFE);
        tick(1);
        rd(2'd3, 8'h00, "R2 no flag at FFFF");
        tick(1);
        rd(2'd1, 8'h00, "R2 wrap lo");
        rd(2'd2, 8'h00, "R2 wrap hi");
        rd(2'd3, 8'h01, "R2 flag set");
        chk_irq(1'b0, "R3 irq masked");
        wr(2'd3, 8'h03);
        chk_irq(1'b1, "R3 irq raised");
        tick(3);
        rd(2'd3, 8'h03, "R3 flag sticky");
        wr(2'd3, 8'h02);
        rd(2'd3, 8'h02, "R3 flag cleared");
        chk_irq(1'b0, "R3 irq dropped");

        // R4 / R5 trigger clears; at FFFF with a tick, flag stays clear
        set8(16'h1234);
        pulse(1'b1, 1'b0, 1'b0);
        rd(2'd1, 8'h00, "R4 trig lo");
        rd(2'd2, 8'h00, "R4 trig hi");
        set8(16'hFFFF);
        pulse(1'b1, 1'b0, 1'b1);
        rd(2'd1, 8'h00, "R5 trig at FFFF lo");
        rd(2'd2, 8'h00, "R5 trig at FFFF hi");
        rd(2'd3, 8'h02, "R5 no flag");

        // R4 select: trig_b ignored with select A
        set8(16'h4321);
        pulse(1'b0, 1'b1, 1'b0);
        rd(2'd1, 8'h21, "R4 trig_b ignored under select A");
        // select B (bits 6,3 = 10)
        setctl(8'h43);
        pulse(1'b0, 1'b1, 1'b0);
        rd(2'd1, 8'h00, "R4 trig_b clears under select B");
        set8(16'h0077);
        pulse(1'b1, 1'b0, 1'b0);
        rd(2'd1, 8'h77, "R4 trig_a ignored under select B");
        // select none
        setctl(8'h03);
        pulse(1'b1, 1'b1, 1'b0);
        rd(2'd1, 8'h77, "R4 no select ignores both");

        // R7 unsynchronized external: trigger ignored
        setctl(8'h0F);
        set8(16'h1234);
        pulse(1'b1, 1'b0, 1'b0);
        rd(2'd2, 8'h12, "R7 hi kept");
        rd(2'd1, 8'h34, "R7 lo kept");

        // R6 write beats trigger, 8-bit and 16-bit
        setctl(8'h0B);
        set8(16'h1234);
        wr_trig(2'd1, 8'h55);
        rd(2'd2, 8'h12, "R6 8-bit hi");
        rd(2'd1, 8'h55, "R6 8-bit lo");
        setctl(8'h88);
        wr(2'd2, 8'hAB);
        wr_trig(2'd1, 8'hCD);
        rd(2'd1, 8'hCD, "R6 16-bit lo");
        rd(2'd2, 8'hAB, "R6 16-bit hi");

        // R10 capture on low read survives a later clear
        pulse(1'b1, 1'b0, 1'b0);
        rd(2'd2, 8'hAB, "R10 hi from capture");
        rd(2'd1, 8'h00, "R10 lo after clear");
        rd(2'd2, 8'h00, "R10 hi recaptured");
        wr(2'd2, 8'h5A);
        rd(2'd1, 8'h00, "R10 hi write buffered only");
        wr(2'd1, 8'h01);
        rd(2'd1, 8'h01, "R10 paired load lo");
        rd(2'd2, 8'h5A, "R10 paired load hi");

        // R8 prescale
        setctl(8'h13);
        set8(16'h0000);
        tick(5);
        rd(2'd1, 8'h02, "R8 div2");
        setctl(8'h23);
        set8(16'h0000);
        tick(8);
        rd(2'd1, 8'h02, "R8 div4");
        tick(3);
        wr(2'd1, 8'h10);
        tick(3);
        rd(2'd1, 8'h10, "R8 prescaler cleared by write");
        tick(1);
        rd(2'd1, 8'h11, "R8 step after clear");
        setctl(8'h33);
        set8(16'h0000);
        tick(8);
        rd(2'd1, 8'h01, "R8 div8");

        // R9 halt holds; writes still act
        setctl(8'h02);
        set8(16'h0040);
        tick(3);
        rd(2'd1, 8'h40, "R9 halted hold");
        // R9 internal source: 21 steps between the two control writes
        setctl(8'h00);
        set8(16'h0000);
        wr(2'd0, 8'h01);
        idle(20);
        wr(2'd0, 8'h00);
        idle(2);
        rd(2'd1, 8'h15, "R9 internal count");
        idle(5);
        rd(2'd1, 8'h15, "R9 stopped hold");
        rd(2'd2, 8'h00, "R9 internal hi");

        idle(2);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule